// File: doc/BRIEF.md
# Coherence Invalidation Traffic Generator

This block is a directed stimulus engine for a multi-core coherent memory system. It works on one address at a time. In the load phase every core, in ascending index order, reads the line so that each core ends up holding a shared copy. One core then issues an invalidating write to the same address. Each write completes one invalidation cycle. After that the engine goes back to the load phase and fills every core again before the next core writes. The address moves on by a fixed stride only once every core has written to it.

The engine drives one request channel with a valid/ready handshake. The channel carries a read/write command, the index of the issuing core, a byte address and a single data byte, which is always zero. There is only one request outstanding at a time. Each completion response must name the core and the address of that request. A completion that does not match, or that arrives when nothing is outstanding, is ignored and sets a sticky error flag. A running count of completed invalidation cycles is exported on its own output.

Top module: `inv_sweep_gen`

## Requirements
- R1: During and after reset, `req_valid`=1, `req_write`=0 (read), `req_core`=0, `req_addr`=0, `cycle_count`=0 and `err_flag`=0.
- R2: In the load phase the engine issues reads (`req_write`=0) from cores 0, 1, …, NUM_CORES-1 in that order. Each read is issued only after the previous request has completed.
- R3: `req_data` is 0 whenever `req_valid` is 1.
- R4: While `req_valid`=1 and `req_ready`=0, the request stays asserted and `req_write`, `req_core` and `req_addr` do not change. The request is retried until it is accepted.
- R5: The request after the read of core NUM_CORES-1 completes is a write (`req_write`=1). It is issued from the write-pointer core, which starts at 0 and goes up by one with each completed write, wrapping after NUM_CORES-1.
- R6: `req_addr` grows by ADDR_STEP (modulo 2^ADDR_W) right after core NUM_CORES-1's write completes, and changes at no other time.
- R7: Each matching write completion raises `cycle_count` by exactly one, and the counter wraps modulo 2^CNT_W. Read completions leave the counter unchanged.
- R8: `req_valid` falls in the cycle after a request is accepted. It stays low until the matching completion arrives, and rises in the cycle after that.
- R9: A completion in a pending phase whose `rsp_core` or `rsp_addr` differs from the outstanding request sets `err_flag`. The request remains outstanding, and `err_flag` stays at 1 until reset.
- R10: A completion that arrives while the engine is not waiting for one (`req_valid`=1) sets `err_flag` and does not change the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Request accepted at this edge when valid |
| req_write | output | 1 | 1 = invalidating write, 0 = read |
| req_core | output | CORE_W | Index of the issuing core |
| req_addr | output | ADDR_W | Byte address of the one-byte access |
| req_data | output | 8 | Write data byte (always zero) |
| rsp_valid | input | 1 | Completion strobe |
| rsp_core | input | CORE_W | Core index carried by the completion |
| rsp_addr | input | ADDR_W | Address carried by the completion |
| cycle_count | output | CNT_W | Completed invalidation cycles, wrapping |
| err_flag | output | 1 | Sticky protocol error |

## Verification
The hardest situation to reach is the point where the address advances. It needs NUM_CORES full load phases, each followed by one write, so NUM_CORES×(NUM_CORES+1) handshakes must all go through correctly. The bench gets there with a responder that echoes every accepted request, using a ready delay and a completion delay that change from one request to the next. A scoreboard checks the full expected request sequence over six addresses, which also makes a narrow cycle counter wrap. The error paths are then reached after a fresh reset. The bench sends a completion while a request is still being offered, then completions carrying a wrong core or a wrong address, and finally a correct one, which must still advance the engine.

// File: rtl/inv_sweep_pkg.sv
package inv_sweep_pkg;

   // Engine phase: offer a request, then wait for its completion
   typedef enum logic [1:0] {
      PH_LD_OFFER  = 2'd0,
      PH_LD_WAIT   = 2'd1,
      PH_INV_OFFER = 2'd2,
      PH_INV_WAIT  = 2'd3
   } sweep_phase_e;

   function automatic int core_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/inv_sweep_ptr.sv
// Wrapping core pointer 0..N-1 with end-of-range flag
module inv_sweep_ptr #(
   parameter int N  = 4,
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [CW-1:0] ptr,
   output logic          at_last
);

   localparam logic [CW-1:0] LAST = CW'(N - 1);

   assign at_last = (ptr == LAST);

   generate
      if ((1 << CW) == N) begin : g_pow2
         // Natural binary wrap covers the full range
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ptr <= '0;
            else if (adv) ptr <= ptr + CW'(1);
         end
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ptr <= '0;
            else if (adv) ptr <= at_last ? '0 : ptr + CW'(1);
         end
      end
   endgenerate

endmodule

// File: rtl/inv_sweep_match.sv
// Compares a completion tag with the outstanding request
module inv_sweep_match #(
   parameter int CW = 2,
   parameter int AW = 32
) (
   input  logic [CW-1:0] got_core,
   input  logic [AW-1:0] got_addr,
   input  logic [CW-1:0] want_core,
   input  logic [AW-1:0] want_addr,
   output logic          hit
);

   assign hit = (got_core == want_core) && (got_addr == want_addr);

endmodule

// File: rtl/inv_sweep_gen.sv
module inv_sweep_gen
   import inv_sweep_pkg::*;
#(
   parameter int          NUM_CORES = 4,
   parameter int          ADDR_W    = 32,
   parameter int unsigned ADDR_STEP = 64,
   parameter int          CNT_W     = 32,
   localparam int         CORE_W    = core_width(NUM_CORES)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              req_valid,
   input  logic              req_ready,
   output logic              req_write,
   output logic [CORE_W-1:0] req_core,
   output logic [ADDR_W-1:0] req_addr,
   output logic [7:0]        req_data,
   input  logic              rsp_valid,
   input  logic [CORE_W-1:0] rsp_core,
   input  logic [ADDR_W-1:0] rsp_addr,
   output logic [CNT_W-1:0]  cycle_count,
   output logic              err_flag
);

   localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(ADDR_STEP);

   generate
      if (NUM_CORES < 1) begin : g_bad_cores
         $error("NUM_CORES must be at least 1");
      end
      if (ADDR_W < 1 || CNT_W < 1) begin : g_bad_width
         $error("ADDR_W and CNT_W must be positive");
      end
   endgenerate

   sweep_phase_e phase_q, phase_d;

   logic [CORE_W-1:0] ld_ptr, inv_ptr;
   logic              ld_last, inv_last;
   logic              ld_adv, inv_adv, addr_adv;
   logic              outstanding, tag_hit, rsp_good;
   logic [CORE_W-1:0] want_core;
   logic [ADDR_W-1:0] addr_q;

   inv_sweep_ptr #(.N(NUM_CORES), .CW(CORE_W)) u_ld_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (ld_adv),
      .ptr     (ld_ptr),
      .at_last (ld_last)
   );

   inv_sweep_ptr #(.N(NUM_CORES), .CW(CORE_W)) u_inv_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (inv_adv),
      .ptr     (inv_ptr),
      .at_last (inv_last)
   );

   assign outstanding = (phase_q == PH_LD_WAIT) || (phase_q == PH_INV_WAIT);
   assign want_core   = (phase_q == PH_INV_WAIT) ? inv_ptr : ld_ptr;

   inv_sweep_match #(.CW(CORE_W), .AW(ADDR_W)) u_match (
      .got_core  (rsp_core),
      .got_addr  (rsp_addr),
      .want_core (want_core),
      .want_addr (addr_q),
      .hit       (tag_hit)
   );

   assign rsp_good = rsp_valid && outstanding && tag_hit;
   assign ld_adv   = rsp_good && (phase_q == PH_LD_WAIT);
   assign inv_adv  = rsp_good && (phase_q == PH_INV_WAIT);
   assign addr_adv = inv_adv && inv_last;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_LD_OFFER:  if (req_ready) phase_d = PH_LD_WAIT;
         PH_LD_WAIT:   if (ld_adv)    phase_d = ld_last ? PH_INV_OFFER : PH_LD_OFFER;
         PH_INV_OFFER: if (req_ready) phase_d = PH_INV_WAIT;
         PH_INV_WAIT:  if (inv_adv)   phase_d = PH_LD_OFFER;
         default:                     phase_d = PH_LD_OFFER;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_LD_OFFER;
         addr_q      <= '0;
         cycle_count <= '0;
         err_flag    <= 1'b0;
      end else begin
         phase_q <= phase_d;
         if (addr_adv)                 addr_q      <= addr_q + STRIDE;
         if (inv_adv)                  cycle_count <= cycle_count + CNT_W'(1);
         if (rsp_valid && !rsp_good)   err_flag    <= 1'b1;
      end
   end

   assign req_valid = (phase_q == PH_LD_OFFER) || (phase_q == PH_INV_OFFER);
   assign req_write = (phase_q == PH_INV_OFFER);
   assign req_core  = req_write ? inv_ptr : ld_ptr;
   assign req_addr  = addr_q;
   assign req_data  = 8'h00;

endmodule

// File: rtl/inv_sweep_chk.sv
module inv_sweep_chk #(
   parameter int          NUM_CORES = 4,
   parameter int          ADDR_W    = 32,
   parameter int unsigned ADDR_STEP = 64,
   parameter int          CNT_W     = 32,
   parameter int          CORE_W    = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_write,
   input logic [CORE_W-1:0] req_core,
   input logic [ADDR_W-1:0] req_addr,
   input logic [7:0]        req_data,
   input logic              rsp_valid,
   input logic [CNT_W-1:0]  cycle_count,
   input logic              err_flag
);

   assert_zero_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> req_data == 8'h00);

   assert_core_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> int'(req_core) < NUM_CORES);

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_write)
                                  && $stable(req_core) && $stable(req_addr));

   assert_quiet_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_valid);

   assert_rise_needs_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid) |-> $past(rsp_valid));

   assert_addr_stride_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(req_addr) |-> req_addr == ADDR_W'($past(req_addr) + ADDR_W'(ADDR_STEP)));

   assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cycle_count) |-> cycle_count == CNT_W'($past(cycle_count) + CNT_W'(1)));

   assert_count_needs_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cycle_count) |-> $past(rsp_valid));

   assert_sticky_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);

   assert_stray_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && req_valid |=> err_flag);

endmodule

bind inv_sweep_gen inv_sweep_chk #(
   .NUM_CORES (NUM_CORES),
   .ADDR_W    (ADDR_W),
   .ADDR_STEP (ADDR_STEP),
   .CNT_W     (CNT_W),
   .CORE_W    (CORE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .req_write   (req_write),
   .req_core    (req_core),
   .req_addr    (req_addr),
   .req_data    (req_data),
   .rsp_valid   (rsp_valid),
   .cycle_count (cycle_count),
   .err_flag    (err_flag)
);

// File: tb/inv_sweep_gen_tb.sv
module inv_sweep_gen_tb;

   localparam int          CLK_PERIOD = 10;
   localparam int          NC   = 3;
   localparam int          AW   = 32;
   localparam int unsigned STEP = 32'h40;
   localparam int          CNTW = 4;
   localparam int          CW   = 2;
   localparam int          NADDR = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid, req_ready = 1'b0, req_write;
   logic [CW-1:0] req_core;
   logic [AW-1:0] req_addr;
   logic [7:0]    req_data;
   logic          rsp_valid = 1'b0;
   logic [CW-1:0] rsp_core = '0;
   logic [AW-1:0] rsp_addr = '0;
   logic [CNTW-1:0] cycle_count;
   logic          err_flag;

   int  n_checks = 0;
   int  n_errs   = 0;
   bit  mon_on   = 1'b0;
   bit  done     = 1'b0;
   int  model_cnt = 0;

   logic [AW+CW:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   inv_sweep_gen #(
      .NUM_CORES (NC),
      .ADDR_W    (AW),
      .ADDR_STEP (STEP),
      .CNT_W     (CNTW)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_write   (req_write),
      .req_core    (req_core),
      .req_addr    (req_addr),
      .req_data    (req_data),
      .rsp_valid   (rsp_valid),
      .rsp_core    (rsp_core),
      .rsp_addr    (rsp_addr),
      .cycle_count (cycle_count),
      .err_flag    (err_flag)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Scoreboard fill: reads of every core, then one write, per write core
   task automatic push_sweep(input int a);
      for (int k = 0; k < NC; k++) begin
         for (int r = 0; r < NC; r++)
            exp_q.push_back({1'b0, CW'(r), AW'(a * STEP)});
         exp_q.push_back({1'b1, CW'(k), AW'(a * STEP)});
      end
   endtask

   // Monitor: compares each accepted request with the scoreboard head
   always begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (mon_on && rst_n && req_valid && req_ready) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected request", longint'({req_write, req_core, req_addr}), 0);
         end else begin
            logic [AW+CW:0] e;
            e = exp_q.pop_front();
            check({req_write, req_core, req_addr} == e,
                  e[AW+CW] ? "R5/R6 write request" : "R2/R6 read request",
                  longint'({req_write, req_core, req_addr}), longint'(e));
         end
      end
   end

   task automatic do_reset();
      rst_n = 1'b0;
      req_ready = 1'b0;
      rsp_valid = 1'b0;
      repeat (3) @(negedge clk);
      check(req_valid == 1'b1 && req_write == 1'b0 && req_core == '0 && req_addr == '0,
            "R1 request in reset", longint'({req_valid, req_write, req_core, req_addr}), 64'h1 << (AW + CW + 1));
      check(cycle_count == '0 && err_flag == 1'b0, "R1 count/err in reset",
            longint'({cycle_count, err_flag}), 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // Serve one request with given ready and completion delays
   task automatic serve(input int rdly, input int sdly);
      logic          s_wr;
      logic [CW-1:0] s_core;
      logic [AW-1:0] s_addr;
      s_wr = req_write; s_core = req_core; s_addr = req_addr;
      check(req_valid == 1'b1, "R8 request offered", longint'(req_valid), 1);
      check(req_data == 8'h00, "R3 data byte", longint'(req_data), 0);
      for (int i = 0; i < rdly; i++) begin
         req_ready = 1'b0;
         @(negedge clk);
         check(req_valid && req_write == s_wr && req_core == s_core && req_addr == s_addr,
               "R4 hold while stalled", longint'({req_valid, req_write, req_core, req_addr}),
               longint'({1'b1, s_wr, s_core, s_addr}));
      end
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      check(req_valid == 1'b0, "R8 low after accept", longint'(req_valid), 0);
      for (int i = 1; i < sdly; i++) begin
         @(negedge clk);
         check(req_valid == 1'b0, "R8 low while outstanding", longint'(req_valid), 0);
      end
      rsp_valid = 1'b1; rsp_core = s_core; rsp_addr = s_addr;
      @(negedge clk);
      rsp_valid = 1'b0;
      if (s_wr) model_cnt++;
      check(cycle_count == CNTW'(model_cnt), s_wr ? "R7 count after write" : "R7 count after read",
            longint'(cycle_count), longint'(CNTW'(model_cnt)));
      check(req_valid == 1'b1, "R8 rises after completion", longint'(req_valid), 1);
   endtask

   initial begin
      do_reset();
      for (int a = 0; a < NADDR; a++) push_sweep(a);
      mon_on = 1'b1;
      for (int n = 0; n < NADDR * NC * (NC + 1); n++)
         serve(n % 3, 1 + (n % 2));
      mon_on = 1'b0;
      check(exp_q.size() == 0, "R2 all requests seen", longint'(exp_q.size()), 0);
      check(req_addr == AW'(NADDR * STEP), "R6 final address", longint'(req_addr), longint'(NADDR * STEP));
      check(err_flag == 1'b0, "R9 no error on clean run", longint'(err_flag), 0);

      // R10: completion while the request is still offered
      do_reset();
      req_ready = 1'b0;
      rsp_valid = 1'b1; rsp_core = '0; rsp_addr = '0;
      @(negedge clk);
      rsp_valid = 1'b0;
      check(err_flag == 1'b1, "R10 stray completion flagged", longint'(err_flag), 1);
      check(req_valid && !req_write && req_core == '0 && req_addr == '0, "R10 request unchanged",
            longint'({req_valid, req_write, req_core, req_addr}), 64'h1 << (AW + CW + 1));
      check(cycle_count == '0, "R10 count unchanged", longint'(cycle_count), 0);

      // R9: wrong core, then wrong address, then the right tag
      do_reset();
      check(err_flag == 1'b0, "R1 error cleared by reset", longint'(err_flag), 0);
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      rsp_valid = 1'b1; rsp_core = CW'(1); rsp_addr = '0;
      @(negedge clk);
      rsp_valid = 1'b0;
      check(err_flag == 1'b1, "R9 wrong core flagged", longint'(err_flag), 1);
      check(req_valid == 1'b0, "R9 still outstanding after wrong core", longint'(req_valid), 0);
      rsp_valid = 1'b1; rsp_core = '0; rsp_addr = AW'(4);
      @(negedge clk);
      rsp_valid = 1'b0;
      check(req_valid == 1'b0, "R9 still outstanding after wrong address", longint'(req_valid), 0);
      rsp_valid = 1'b1; rsp_core = '0; rsp_addr = '0;
      @(negedge clk);
      rsp_valid = 1'b0;
      check(req_valid && !req_write && req_core == CW'(1), "R9 correct completion advances",
            longint'({req_valid, req_write, req_core}), longint'({1'b1, 1'b0, CW'(1)}));
      check(err_flag == 1'b1, "R9 error stays set", longint'(err_flag), 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errs++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

endmodule